// File: doc/BRIEF.md
# Branch Condition and Target Unit

This block decides whether a conditional instruction's condition holds for the current processor status flags. It takes a 4-bit condition selector and five flag inputs: zero, sign, overflow, carry and a sticky saturation flag. From the same evaluation it produces three registered results. The first is a branch-taken bit. The second is the next fetch address: the PC plus a sign-extended 9-bit displacement when the branch is taken, otherwise the PC plus the 2-byte instruction size. The third is a 32-bit word that holds the condition bit in bit 0 and zeros above it. A set-flag-to-register instruction writes that word to its destination.

Instruction decode and fetch are handled elsewhere, and so is flag maintenance. The flags are plain inputs, sampled together with the selector, PC and displacement whenever `in_valid` is high. All results appear one clock later, qualified by `out_valid`.

Top module: `cond_br_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `out_taken`, `out_target` and `out_setf` are all cleared at that edge.
- R2: Selector codes 0, 1, 2 and 4 are true when the overflow, carry, zero and sign flag is set, respectively. Codes 8, 9, 10 and 12 are true when the same flag is clear.
- R3: Code 3 (unsigned lower-or-same) is true when carry OR zero is set. Code 11 (unsigned higher) is its negation.
- R4: Code 6 (signed less-than) is true when sign XOR overflow is 1. Code 14 (signed greater-or-equal) is its negation.
- R5: Code 7 (signed less-or-equal) is true when zero OR (sign XOR overflow) is 1. Code 15 (signed greater-than) is its negation.
- R6: Code 5 is always true for every flag value. Code 13 is true exactly when the saturation flag is set.
- R7: `out_valid` equals `in_valid` of the previous cycle. `out_taken` is 1 only when the previous cycle carried a valid request whose condition held.
- R8: For a taken branch, `out_target` equals the request's PC plus its 9-bit displacement sign-extended, modulo 2^32.
- R9: For a request whose condition is false, `out_target` equals the request's PC plus 2, modulo 2^32.
- R10: For a valid request, `out_setf` bit 0 equals the condition result and bits 31..1 are zero.
- R11: A cycle with `in_valid` low leaves `out_target` and `out_setf` unchanged and drives `out_taken` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_cc | input | 4 | Condition selector (codes per R2 to R6) |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| flag_sat | input | 1 | Sticky saturation flag |
| in_pc | input | 32 | Address of the conditional instruction |
| in_disp | input | 9 | Signed branch displacement |
| out_valid | output | 1 | Results below are from a request |
| out_taken | output | 1 | Branch taken |
| out_target | output | 32 | Next fetch address |
| out_setf | output | 32 | Condition bit zero-extended to 32 bits |

## Verification
Each of the sixteen selector codes is driven against all 32 combinations of the five flags. This sweep separates every code from its negated partner, and it separates the compound terms from their single-flag parts: carry alone against carry with zero, and sign against overflow with and without zero. The saturation code is kept apart from the always-true code. The PC and displacement vary with each request, so that positive, negative and extreme displacements and PC wrap-around tell the taken address apart from the fall-through address. Idle cycles are mixed in to show that the previous results are held.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

  typedef enum logic [3:0] {
    CC_V  = 4'h0, CC_C  = 4'h1, CC_Z  = 4'h2, CC_NH = 4'h3,
    CC_N  = 4'h4, CC_T  = 4'h5, CC_LT = 4'h6, CC_LE = 4'h7,
    CC_NV = 4'h8, CC_NC = 4'h9, CC_NZ = 4'hA, CC_H  = 4'hB,
    CC_NS = 4'hC, CC_SA = 4'hD, CC_GE = 4'hE, CC_GT = 4'hF
  } cc_e;

  typedef struct packed {
    logic z;
    logic s;
    logic v;
    logic c;
    logic sat;
  } flags_t;

endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import cond_eval_pkg::*;
(
  input  logic [3:0] cc,
  input  flags_t     fl,
  output logic       hit
);
  // The low three bits pick a base term; bit 3 inverts it.
  // Code 13 replaces the inverted always-true term with saturation.
  logic lt_term;
  logic base;

  assign lt_term = fl.s ^ fl.v;

  always_comb begin
    unique case (cc[2:0])
      3'd0: base = fl.v;
      3'd1: base = fl.c;
      3'd2: base = fl.z;
      3'd3: base = fl.c | fl.z;
      3'd4: base = fl.s;
      3'd5: base = 1'b1;
      3'd6: base = lt_term;
      default: base = fl.z | lt_term;
    endcase
  end

  always_comb begin
    if (cc == CC_SA) hit = fl.sat;
    else             hit = base ^ cc[3];
  end
endmodule

// File: rtl/target_calc.sv
module target_calc #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 9,
  parameter int STEP   = 2
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              take,
  output logic [ADDR_W-1:0] next
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] incr;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign incr     = take ? disp_ext : ADDR_W'(STEP);
  assign next     = pc + incr;
endmodule

// File: rtl/cond_br_unit.sv
module cond_br_unit
  import cond_eval_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 9,
  parameter int RES_W  = 32,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        in_cc,
  input  logic              flag_z,
  input  logic              flag_s,
  input  logic              flag_v,
  input  logic              flag_c,
  input  logic              flag_sat,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [DISP_W-1:0] in_disp,
  output logic              out_valid,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_target,
  output logic [RES_W-1:0]  out_setf
);
  localparam int PAD_W = RES_W - 1;

  flags_t            fl;
  logic              hit;
  logic [ADDR_W-1:0] next_pc;

  assign fl = '{z: flag_z, s: flag_s, v: flag_v, c: flag_c, sat: flag_sat};

  cond_eval u_eval (
    .cc  (in_cc),
    .fl  (fl),
    .hit (hit)
  );

  target_calc #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .STEP   (STEP)
  ) u_tgt (
    .pc   (in_pc),
    .disp (in_disp),
    .take (hit),
    .next (next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_taken  <= 1'b0;
      out_target <= '0;
      out_setf   <= '0;
    end else begin
      out_valid <= in_valid;
      out_taken <= in_valid & hit;
      if (in_valid) begin
        out_target <= next_pc;
        out_setf   <= {{PAD_W{1'b0}}, hit};
      end
    end
  end
endmodule

// File: rtl/cond_br_unit_chk.sv
module cond_br_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 9,
  parameter int RES_W  = 32,
  parameter int STEP   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        in_cc,
  input logic              flag_sat,
  input logic [ADDR_W-1:0] in_pc,
  input logic [DISP_W-1:0] in_disp,
  input logic              out_valid,
  input logic              out_taken,
  input logic [ADDR_W-1:0] out_target,
  input logic [RES_W-1:0]  out_setf
);
  localparam int EXT_W = ADDR_W - DISP_W;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_taken && out_target == '0 && out_setf == '0));

  // R7
  taken_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_taken |-> out_valid);

  // R7
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R6
  always_code_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cc == 4'h5) |=> out_taken);

  // R6
  sat_code_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cc == 4'hD) |=> (out_taken == $past(flag_sat)));

  // R10
  setf_matches_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_setf[RES_W-1:1] == '0 && out_setf[0] == out_taken));

  // R8
  taken_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && out_taken) |->
      (out_target == $past(in_pc) + {{EXT_W{$past(in_disp[DISP_W-1])}}, $past(in_disp)}));

  // R9
  fall_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && out_valid && !out_taken) |->
      (out_target == $past(in_pc) + ADDR_W'(STEP)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |->
      ($stable(out_target) && $stable(out_setf) && !out_taken));
endmodule

bind cond_br_unit cond_br_unit_chk #(
  .ADDR_W (ADDR_W),
  .DISP_W (DISP_W),
  .RES_W  (RES_W),
  .STEP   (STEP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_cc      (in_cc),
  .flag_sat   (flag_sat),
  .in_pc      (in_pc),
  .in_disp    (in_disp),
  .out_valid  (out_valid),
  .out_taken  (out_taken),
  .out_target (out_target),
  .out_setf   (out_setf)
);

// File: tb/tb_cond_br_unit.sv
module tb_cond_br_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  in_cc = '0;
  logic        flag_z = 1'b0, flag_s = 1'b0, flag_v = 1'b0, flag_c = 1'b0, flag_sat = 1'b0;
  logic [31:0] in_pc = '0;
  logic [8:0]  in_disp = '0;
  logic        out_valid, out_taken;
  logic [31:0] out_target, out_setf;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0]  cc;
    logic        t;
    logic [31:0] tgt;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  cond_br_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cc(in_cc),
    .flag_z(flag_z), .flag_s(flag_s), .flag_v(flag_v), .flag_c(flag_c),
    .flag_sat(flag_sat), .in_pc(in_pc), .in_disp(in_disp),
    .out_valid(out_valid), .out_taken(out_taken),
    .out_target(out_target), .out_setf(out_setf)
  );

  function automatic logic ref_cond(input logic [3:0] cc, input logic z, s, v, c, sat);
    case (cc)
      4'h0: return v;
      4'h1: return c;
      4'h2: return z;
      4'h3: return c || z;
      4'h4: return s;
      4'h5: return 1'b1;
      4'h6: return s != v;
      4'h7: return z || (s != v);
      4'h8: return !v;
      4'h9: return !c;
      4'hA: return !z;
      4'hB: return !(c || z);
      4'hC: return !s;
      4'hD: return sat;
      4'hE: return s == v;
      default: return !(z || (s != v));
    endcase
  endfunction

  function automatic string cc_tag(input logic [3:0] cc);
    case (cc)
      4'h3, 4'hB: return "R3";
      4'h6, 4'hE: return "R4";
      4'h7, 4'hF: return "R5";
      4'h5, 4'hD: return "R6";
      default:    return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] cc, input logic [4:0] f,
                       input logic [31:0] pc, input logic [8:0] d);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_cc = cc;
    {flag_z, flag_s, flag_v, flag_c, flag_sat} = f;
    in_pc = pc; in_disp = d;
    e.cc  = cc;
    e.t   = ref_cond(cc, f[4], f[3], f[2], f[1], f[0]);
    e.tgt = e.t ? pc + {{23{d[8]}}, d} : pc + 32'd2;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_pc = 32'hDEAD_BEEF; in_disp = 9'h0AA; in_cc = 4'h5;
  endtask

  logic [31:0] last_tgt = '0, last_setf = '0;

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          chk("R7 unexpected result", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({cc_tag(e.cc), " taken"}, {31'd0, out_taken}, {31'd0, e.t});
          chk(e.t ? "R8 taken target" : "R9 fallthrough target", out_target, e.tgt);
          chk("R10 setf word", out_setf, {31'd0, e.t});
        end
      end else begin
        chk("R7 idle taken", {31'd0, out_taken}, 32'd0);
        chk("R11 target held", out_target, last_tgt);
        chk("R11 setf held", out_setf, last_setf);
      end
      last_tgt  = out_target;
      last_setf = out_setf;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R1 taken after reset", {31'd0, out_taken}, 32'd0);
    chk("R1 target after reset", out_target, 32'd0);
    chk("R1 setf after reset", out_setf, 32'd0);
    rst = 1'b0;
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 32; f++) begin
        int k;
        k = cc * 32 + f;
        drive(4'(cc), 5'(f), 32'hFFFF_FF80 + 32'(k * 6), 9'(k * 37 + 255));
        if (k % 7 == 3) idle();
      end
    end
    // Displacement extremes: +255, -256, -1 with an always-true code
    drive(4'h5, 5'd0, 32'h0000_0100, 9'h0FF);
    drive(4'h5, 5'd0, 32'h0000_0100, 9'h100);
    drive(4'h5, 5'd0, 32'h0000_0000, 9'h1FF);
    drive(4'hD, 5'd0, 32'hFFFF_FFFE, 9'h010);
    idle();
    idle();
    @(negedge clk);
    chk("R7 queue drained", 32'(q.size()), 32'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule